// File: doc/BRIEF.md
# Polled Random Word Register

This block holds one random word for software to pick up by polling. It fetches the word from an entropy source over a request/acknowledge handshake. Software first reads a status register and checks its valid flag. When the flag is set, software reads the data register. That read returns the word, empties the holder and starts a fresh fetch in the same clock edge.

The holder is always in one of two states. Either it has a valid word, or a request to the entropy source is outstanding. Leaving reset counts as emptying the holder, so a request goes out at once. The request stays asserted until the source acknowledges it. The word that comes with the acknowledge is latched on that cycle. Read data is combinational on the read port, and any side effect of a read takes place at the next rising clock edge.

Top module: `rnd_word_reg`

## Requirements
- R1: While reset is applied and after it is released, the holder is empty: `ent_req` is 1, and a status read returns 0.
- R2: A read of the status address (`STAT_OFS`, default 0x4) returns the valid flag in bit 0, with all other bits 0.
- R3: While the holder is empty and `ent_ack` is low, `ent_req` stays asserted on every following cycle.
- R4: When `ent_req` and `ent_ack` are both high at a rising edge, the word on `ent_data` is latched. From the next cycle the holder is valid and `ent_req` is low.
- R5: A read of the data address (`DATA_OFS`, default 0x0) while valid returns the held word in that cycle. From the next cycle the holder is empty and `ent_req` is 1.
- R6: A read of the data address while the holder is empty returns 0.
- R7: A data read while the holder is empty has no side effect: `ent_req` stays at 1 and no second request is started.
- R8: When a data read and an acknowledge arrive in the same cycle while the holder is empty, the read returns 0. The acknowledged word is latched and is valid from the next cycle.
- R9: `ent_req` is always the inverse of the valid flag. The holder is never empty without a request outstanding.
- R10: An `ent_ack` while the holder is valid is ignored, and the held word is unchanged.
- R11: A read of any other address returns 0 and has no side effect. With `rd_en` low, `rd_data` is 0.
- R12: A status read does not consume the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register byte address |
| rd_data | output | DATA_W | Read data, valid in the cycle of `rd_en` |
| ent_req | output | 1 | Request to the entropy source |
| ent_ack | input | 1 | Entropy source acknowledge |
| ent_data | input | DATA_W | Entropy word, sampled on acknowledge |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 4-bit address, data at 0x0 and status at 0x4. The 4-bit address space reaches the two unmapped addresses 0x8 and 0xC, which are used to check that stray reads stay harmless. The full 32-bit word lets distinct values show that acknowledges arriving while the holder is valid are dropped. A random phase then mixes reads and acknowledges in every combination of the two states, including reads and acknowledges that land in the same cycle.

// File: rtl/rnd_word_pkg.sv
package rnd_word_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_FILL    = 2'd1,
        ACT_CONSUME = 2'd2
    } slot_act_e;

    typedef struct packed {
        logic hit_data;
        logic hit_stat;
    } rd_sel_t;

    // Decide what the slot does on this edge.
    function automatic slot_act_e slot_next_act(
        input slot_state_e st,
        input logic        ack,
        input logic        data_rd
    );
        slot_act_e act;
        act = ACT_HOLD;
        if (st == SLOT_EMPTY) begin
            if (ack) act = ACT_FILL;
        end else begin
            if (data_rd) act = ACT_CONSUME;
        end
        return act;
    endfunction

endpackage

// File: rtl/rnd_addr_dec.sv
module rnd_addr_dec
    import rnd_word_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_OFS = 0,
    parameter int STAT_OFS = 4
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_sel_t           sel
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    always_comb begin
        sel.hit_data = rd_en && (rd_addr == DATA_A);
        sel.hit_stat = rd_en && (rd_addr == STAT_A);
    end
endmodule

// File: rtl/rnd_slot.sv
module rnd_slot
    import rnd_word_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  logic [DATA_W-1:0] ack_word,
    input  logic              data_rd,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    slot_state_e       st_q;
    logic [DATA_W-1:0] word_q;
    slot_act_e         act;

    always_comb act = slot_next_act(st_q, ack, data_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SLOT_EMPTY;
            word_q <= '0;
        end else begin
            case (act)
                ACT_FILL: begin
                    st_q   <= SLOT_FULL;
                    word_q <= ack_word;
                end
                ACT_CONSUME: begin
                    st_q   <= SLOT_EMPTY;
                    word_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign full = (st_q == SLOT_FULL);
    assign word = word_q;
endmodule

// File: rtl/rnd_rd_mux.sv
module rnd_rd_mux
    import rnd_word_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  rd_sel_t           sel,
    input  logic              full,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (sel.hit_data && full) rd_data = word;
        else if (sel.hit_stat)    rd_data = {{(DATA_W-1){1'b0}}, full};
    end
endmodule

// File: rtl/rnd_word_reg.sv
module rnd_word_reg
    import rnd_word_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int DATA_OFS = 0,
    parameter int STAT_OFS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ent_req,
    input  logic              ent_ack,
    input  logic [DATA_W-1:0] ent_data
);
    rd_sel_t           sel;
    logic              full;
    logic [DATA_W-1:0] word;

    rnd_addr_dec #(
        .ADDR_W  (ADDR_W),
        .DATA_OFS(DATA_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_dec (
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .sel    (sel)
    );

    rnd_slot #(.DATA_W(DATA_W)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .ack     (ent_ack),
        .ack_word(ent_data),
        .data_rd (sel.hit_data),
        .full    (full),
        .word    (word)
    );

    rnd_rd_mux #(.DATA_W(DATA_W)) u_mux (
        .sel    (sel),
        .full   (full),
        .word   (word),
        .rd_data(rd_data)
    );

    // Empty always means a fetch is outstanding.
    assign ent_req = ~full;
endmodule

// File: rtl/rnd_word_reg_chk.sv
module rnd_word_reg_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int DATA_OFS = 0,
    parameter int STAT_OFS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              ent_req,
    input logic              ent_ack,
    input logic [DATA_W-1:0] ent_data
);
    logic data_rd, stat_rd;
    assign data_rd = rd_en && (rd_addr == ADDR_W'(DATA_OFS));
    assign stat_rd = rd_en && (rd_addr == ADDR_W'(STAT_OFS));

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ent_req && !ent_ack) |=> ent_req); // R3

    AST_ACK_FILLS: assert property (@(posedge clk) disable iff (rst)
        (ent_req && ent_ack) |=> !ent_req); // R4

    AST_CONSUME_REREQ: assert property (@(posedge clk) disable iff (rst)
        (!ent_req && data_rd) |=> ent_req); // R5

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ent_req && data_rd) |-> (rd_data == '0)); // R6

    AST_EMPTY_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (ent_req && data_rd && !ent_ack) |=> ent_req); // R7

    AST_STATUS_MATCHES_REQ: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (rd_data == {{(DATA_W-1){1'b0}}, !ent_req})); // R9

    AST_STATUS_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
        (!ent_req && !data_rd) |=> !ent_req); // R12

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0)); // R11
endmodule

bind rnd_word_reg rnd_word_reg_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .DATA_OFS(DATA_OFS),
    .STAT_OFS(STAT_OFS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ent_req (ent_req),
    .ent_ack (ent_ack),
    .ent_data(ent_data)
);

// File: tb/sim_rnd_word_reg.sv
module sim_rnd_word_reg;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ent_req;
    logic          ent_ack = 1'b0;
    logic [DW-1:0] ent_data = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit          m_valid = 0;
    logic [DW-1:0] m_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_word_reg u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ent_req(ent_req), .ent_ack(ent_ack),
        .ent_data(ent_data)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(bit en, logic [AW-1:0] a);
        if (!en) return '0;
        if (a == 4'h0) return m_valid ? m_word : '0;
        if (a == 4'h4) return {{(DW-1){1'b0}}, m_valid};
        return '0;
    endfunction

    // One cycle: drive at negedge, check, then advance the model at posedge.
    task automatic step(input bit en, input logic [AW-1:0] a, input bit ack,
                        input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        rd_en = en; rd_addr = a; ent_ack = ack; ent_data = d;
        #1;
        check({tag, " R9 req"}, {31'b0, ent_req}, {31'b0, !m_valid});
        check({tag, " rd_data"}, rd_data, exp_rd(en, a));
        @(posedge clk);
        if (!m_valid && ack) begin
            m_valid = 1; m_word = d;
        end else if (m_valid && en && a == 4'h0) begin
            m_valid = 0; m_word = '0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd_en = 1; rd_addr = 4'h4; #1;
        check("R1 req in reset", {31'b0, ent_req}, 32'd1);
        check("R1 status in reset", rd_data, 32'd0);
        rst = 0;
        step(1, 4'h4, 0, '0, "R1 after reset");
        step(0, 4'h0, 0, '0, "R3 hold");
        step(0, 4'h0, 0, '0, "R3 hold");
        step(1, 4'h0, 0, 32'h1111_1111, "R6 R7 empty read");
        step(1, 4'h0, 0, '0, "R7 empty read again");
        step(0, 4'h0, 1, 32'hDEAD_BEEF, "R4 ack");
        step(1, 4'h4, 0, '0, "R2 R4 status valid");
        step(1, 4'h4, 0, '0, "R12 status again");
        step(0, 4'h0, 1, 32'h0BAD_0BAD, "R10 stray ack");
        step(1, 4'h8, 0, '0, "R11 unmapped 8");
        step(1, 4'hC, 0, '0, "R11 unmapped C");
        step(1, 4'h0, 0, '0, "R5 R10 consume");
        step(1, 4'h4, 0, '0, "R5 empty after consume");
        step(1, 4'h0, 1, 32'hCAFE_F00D, "R8 read+ack");
        step(1, 4'h4, 0, '0, "R8 valid next");
        step(1, 4'h0, 0, '0, "R8 word latched");
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 3) * 4);
            step(1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)),
                 DW'($urandom), "R9 random");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule